// File: doc/BRIEF.md
# Carry select adder

This block adds two unsigned operands and an incoming carry in a single combinational pass. The operands are split into a lower block and an upper block of equal width. The lower block is summed once, using the external carry. The upper block is summed twice at the same time: one copy assumes a carry of zero and the other assumes a carry of one. The real carry out of the lower block then chooses between the two upper results.

The lower carry is the signal that arrives late. It is used only as the select input of a 2:1 multiplexer, so the upper sum never waits for that carry to ripple through the upper bits. Each block is a ripple chain of full adders. The block width is a parameter, and the default of 4 gives an 8-bit adder with a 9-bit result. The block has no clock and no state. Its data pins are plain, with no handshake, because every result is ready within the same cycle as its inputs.

Top module: `carry_sel_adder`

## Requirements
- R1: For every pair of operands and both carry-in values, {c_out, sum_out} equals a_in + b_in + c_in, taken as an unsigned number of 2*BLK_W+1 bits.
- R2: sum_out[BLK_W-1:0] equals the low BLK_W bits of a_in[BLK_W-1:0] + b_in[BLK_W-1:0] + c_in.
- R3: When a_in[BLK_W-1:0] + b_in[BLK_W-1:0] + c_in is less than 2**BLK_W, {c_out, sum_out[2*BLK_W-1:BLK_W]} equals the upper operand halves added with no carry.
- R4: When a_in[BLK_W-1:0] + b_in[BLK_W-1:0] + c_in is 2**BLK_W or more, {c_out, sum_out[2*BLK_W-1:BLK_W]} equals the upper operand halves plus one.
- R5: When the lower carry must pass through an all-ones upper half, the result is still correct. With default widths, 0xFF + 0x00 + 1 gives sum_out 0x00 and c_out 1, and 0xFF + 0xFF + 1 gives sum_out 0xFF and c_out 1.
- R6: An upper half that produces a carry on its own sets c_out whatever the lower carry is. With default widths, 0x80 + 0x80 + 0 gives sum_out 0x00 and c_out 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_in | input | 2*BLK_W | First operand, unsigned |
| b_in | input | 2*BLK_W | Second operand, unsigned |
| c_in | input | 1 | Carry into bit 0 |
| sum_out | output | 2*BLK_W | Sum bits |
| c_out | output | 1 | Carry out of the top bit |

## Verification
The bench builds the adder only with the default BLK_W of 4. That gives 8-bit operands, small enough to sweep every operand pair with both carry-in values. The sweep reaches every pattern of the lower carry and the upper operands, so both selector paths (R3, R4) are exercised for every upper-half value, not just for a sample. A short hand-written table then pins down the carry chains that cross the block boundary and the cases where the upper half carries out on its own.

// File: rtl/csa_pkg.sv
package csa_pkg;
  localparam int unsigned CSA_DEF_BLK_W = 4;

  function automatic logic fa_sum(input logic a, input logic b, input logic ci);
    return a ^ b ^ ci;
  endfunction

  function automatic logic fa_carry(input logic a, input logic b, input logic ci);
    return (a & b) | (ci & (a ^ b));
  endfunction
endpackage

// File: rtl/csa_ripple_blk.sv
module csa_ripple_blk
  import csa_pkg::*;
#(
  parameter int unsigned W = 4
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         ci,
  output logic [W-1:0] s,
  output logic         co
);
  logic [W:0] chain;
  assign chain[0] = ci;

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign s[i]       = fa_sum(a[i], b[i], chain[i]);
    assign chain[i+1] = fa_carry(a[i], b[i], chain[i]);
  end

  assign co = chain[W];
endmodule

// File: rtl/csa_sel_mux.sv
module csa_sel_mux #(
  parameter int unsigned W = 5
) (
  input  logic         sel,
  input  logic [W-1:0] d0,
  input  logic [W-1:0] d1,
  output logic [W-1:0] y
);
  always_comb begin
    y = sel ? d1 : d0;
  end
endmodule

// File: rtl/carry_sel_adder.sv
module carry_sel_adder
  import csa_pkg::*;
#(
  parameter int unsigned BLK_W = CSA_DEF_BLK_W
) (
  input  logic [2*BLK_W-1:0] a_in,
  input  logic [2*BLK_W-1:0] b_in,
  input  logic               c_in,
  output logic [2*BLK_W-1:0] sum_out,
  output logic               c_out
);
  localparam int unsigned TOT_W = 2 * BLK_W;
  localparam int unsigned RES_W = BLK_W + 1;

  logic [BLK_W-1:0] lo_sum;
  logic             lo_co;
  logic [BLK_W-1:0] hi_sum0, hi_sum1;
  logic             hi_co0, hi_co1;
  logic [RES_W-1:0] hi_pick;

  csa_ripple_blk #(.W(BLK_W)) u_lo (
    .a (a_in[BLK_W-1:0]),
    .b (b_in[BLK_W-1:0]),
    .ci(c_in),
    .s (lo_sum),
    .co(lo_co)
  );

  csa_ripple_blk #(.W(BLK_W)) u_hi0 (
    .a (a_in[TOT_W-1:BLK_W]),
    .b (b_in[TOT_W-1:BLK_W]),
    .ci(1'b0),
    .s (hi_sum0),
    .co(hi_co0)
  );

  csa_ripple_blk #(.W(BLK_W)) u_hi1 (
    .a (a_in[TOT_W-1:BLK_W]),
    .b (b_in[TOT_W-1:BLK_W]),
    .ci(1'b1),
    .s (hi_sum1),
    .co(hi_co1)
  );

  csa_sel_mux #(.W(RES_W)) u_sel (
    .sel(lo_co),
    .d0 ({hi_co0, hi_sum0}),
    .d1 ({hi_co1, hi_sum1}),
    .y  (hi_pick)
  );

  assign sum_out = {hi_pick[BLK_W-1:0], lo_sum};
  assign c_out   = hi_pick[BLK_W];
endmodule

// File: rtl/carry_sel_adder_chk.sv
module carry_sel_adder_chk #(
  parameter int unsigned BLK_W = 4
) (
  input logic [2*BLK_W-1:0] a_in,
  input logic [2*BLK_W-1:0] b_in,
  input logic               c_in,
  input logic [2*BLK_W-1:0] sum_out,
  input logic               c_out,
  input logic               lo_co,
  input logic [BLK_W-1:0]   hi_sum0,
  input logic [BLK_W-1:0]   hi_sum1,
  input logic               hi_co0,
  input logic               hi_co1
);
  localparam int unsigned TOT_W = 2 * BLK_W;

  logic [TOT_W:0]   full_ref;
  logic [BLK_W:0]   lo_ref;
  logic [BLK_W:0]   cand0, cand1, hi_out;

  always_comb begin
    full_ref = (TOT_W+1)'(a_in) + (TOT_W+1)'(b_in) + (TOT_W+1)'(c_in);
    lo_ref   = (BLK_W+1)'(a_in[BLK_W-1:0]) + (BLK_W+1)'(b_in[BLK_W-1:0])
             + (BLK_W+1)'(c_in);
    cand0    = {hi_co0, hi_sum0};
    cand1    = {hi_co1, hi_sum1};
    hi_out   = {c_out, sum_out[TOT_W-1:BLK_W]};

    p_full_sum_r1: assert ({c_out, sum_out} == full_ref);
    p_low_half_r2: assert (sum_out[BLK_W-1:0] == lo_ref[BLK_W-1:0]);
    p_pick_zero_r3: assert (lo_co || (hi_out == cand0));
    p_pick_one_r4: assert (!lo_co || (hi_out == cand1));
    p_cand_step_r4: assert (cand1 == cand0 + (BLK_W+1)'(1));
    p_lo_carry_r3: assert (lo_co == lo_ref[BLK_W]);
  end
endmodule

bind carry_sel_adder carry_sel_adder_chk #(.BLK_W(BLK_W)) u_chk (
  .a_in   (a_in),
  .b_in   (b_in),
  .c_in   (c_in),
  .sum_out(sum_out),
  .c_out  (c_out),
  .lo_co  (lo_co),
  .hi_sum0(hi_sum0),
  .hi_sum1(hi_sum1),
  .hi_co0 (hi_co0),
  .hi_co1 (hi_co1)
);

// File: tb/sim_carry_sel_adder.sv
`timescale 1ns/1ps
module sim_carry_sel_adder;
  logic       clk = 1'b0;
  logic [7:0] a_in = 8'h00;
  logic [7:0] b_in = 8'h00;
  logic       c_in = 1'b0;
  logic [7:0] sum_out;
  logic       c_out;

  int checks   = 0;
  int failures = 0;
  int cycles   = 0;
  bit done     = 1'b0;

  always #10 clk = ~clk;

  carry_sel_adder #(.BLK_W(4)) u0 (
    .a_in   (a_in),
    .b_in   (b_in),
    .c_in   (c_in),
    .sum_out(sum_out),
    .c_out  (c_out)
  );

  // entry: a[25:18] b[17:10] c[9] expected {carry,sum}[8:0]
  localparam logic [25:0] VEC [13] = '{
    {8'h00, 8'h00, 1'b0, 9'h000},
    {8'h00, 8'h00, 1'b1, 9'h001},
    {8'h0F, 8'h01, 1'b0, 9'h010},
    {8'h0F, 8'h00, 1'b1, 9'h010},
    {8'hFF, 8'h00, 1'b1, 9'h100},
    {8'hFF, 8'hFF, 1'b1, 9'h1FF},
    {8'hFF, 8'hFF, 1'b0, 9'h1FE},
    {8'h80, 8'h80, 1'b0, 9'h100},
    {8'hF0, 8'h10, 1'b0, 9'h100},
    {8'h7F, 8'h01, 1'b0, 9'h080},
    {8'hA5, 8'h5A, 1'b0, 9'h0FF},
    {8'hA5, 8'h5A, 1'b1, 9'h100},
    {8'h08, 8'h08, 1'b0, 9'h010}
  };

  task automatic check(input string req, input logic [8:0] got, input logic [8:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s a=%h b=%h c=%0d actual=%h expected=%h", req, a_in, b_in, c_in, got, exp);
    end
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (!done && cycles >= 150000) begin
        checks++;
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
      end
    end
  end

  initial begin
    // idle state: zero inputs give zero result (R1)
    #5;
    check("R1", {c_out, sum_out}, 9'h000);

    // table walk: chains across the block boundary (R5, R6)
    for (int i = 0; i < 13; i++) begin
      a_in = VEC[i][25:18];
      b_in = VEC[i][17:10];
      c_in = VEC[i][9];
      #1;
      check((i == 7 || i == 8) ? "R6" : "R5", {c_out, sum_out}, VEC[i][8:0]);
    end

    // exhaustive sweep: full result, low half, and upper half by lower carry
    for (int c = 0; c < 2; c++) begin
      for (int a = 0; a < 256; a++) begin
        for (int b = 0; b < 256; b++) begin
          logic [8:0] full_exp;
          logic [4:0] lo_exp;
          logic [4:0] hi_exp;
          a_in = 8'(a);
          b_in = 8'(b);
          c_in = 1'(c);
          #1;
          full_exp = 9'(a) + 9'(b) + 9'(c);
          lo_exp   = 5'(a % 16) + 5'(b % 16) + 5'(c);
          hi_exp   = 5'(a / 16) + 5'(b / 16) + 5'(lo_exp[4]);
          check("R1", {c_out, sum_out}, full_exp);
          check("R2", {5'b0, sum_out[3:0]}, {5'b0, lo_exp[3:0]});
          if (lo_exp[4])
            check("R4", {4'b0, c_out, sum_out[7:4]}, {4'b0, hi_exp});
          else
            check("R3", {4'b0, c_out, sum_out[7:4]}, {4'b0, hi_exp});
        end
      end
    end

    // directed corner: all-ones operand plus carry-in only (R5)
    a_in = 8'hFF; b_in = 8'h00; c_in = 1'b1;
    #1;
    check("R5", {c_out, sum_out}, 9'h100);
    // upper half carries on its own with the lower carry clear (R6)
    a_in = 8'hC3; b_in = 8'h40; c_in = 1'b0;
    #1;
    check("R6", {c_out, sum_out}, 9'h103);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule